// File: doc/BRIEF.md
# Machine-mode interrupt trap controller

This block decides when a single-hart processor core that runs only in machine mode takes an asynchronous interrupt. It holds the trap-related state: status, interrupt enable, interrupt pending, trap vector, saved exception PC and cause. Each cycle it checks the three interrupt sources (software, timer, external) against their enable bits and the global enable bit. When an interrupt is taken, or when the core retires a return-from-trap (MRET) instruction, it updates that state and issues a one-cycle redirect to the fetch stage.

CSR address decode happens outside the block. The surrounding pipeline presents one write strobe per register and a shared write-data bus. The current register values are always visible at the outputs. Every trap is handled in machine mode. There is no delegation and no lower privilege level, and the trap vector is used in direct mode only.

Top module: `mtrap_irq_ctrl`

## Requirements
- R1: After reset, the redirect-valid output is 0 and the status, enable, pending, vector, exception-PC and cause outputs are all zero.
- R2: Pending bit 7 (timer) and bit 11 (external) copy the timer and external request lines at every clock edge, one cycle late. A software write to the pending register leaves them unchanged. Pending bit 3 (software) is set while the software request line is high, and otherwise takes bit 3 of a pending write.
- R3: An interrupt is taken only when status bit 3 (global enable) is 1 and, for the same source, both the enable bit and the pending bit are 1. The source bit positions are 3 (software), 7 (timer) and 11 (external).
- R4: When more than one source is enabled and pending, the external source wins over software, and software wins over timer.
- R5: On interrupt entry, status bit 7 takes the old value of status bit 3, status bit 3 is cleared, and status bits 12:11 become 2'b11.
- R6: On interrupt entry, the cause register becomes bit 31 set plus the source code (3, 7 or 11) in the low bits. The exception-PC register captures `pc_i` from the deciding cycle.
- R7: The cycle after an interrupt decision, `redir_vld_o` is 1 for one cycle and `redir_pc_o` equals the trap vector.
- R8: An MRET sets status bit 3 to the old status bit 7, sets status bit 7 to 1 and sets bits 12:11 to 2'b11. The next cycle, it redirects to the exception-PC register value.
- R9: If MRET and a takeable interrupt fall in the same cycle, only the MRET is performed. The interrupt is re-evaluated in the next cycle with the restored enable bit.
- R10: Software writes are masked. The enable register keeps only bits 3, 7 and 11. Status keeps only bits 3, 7, 12 and 11. The trap vector has bits 1:0 forced to 0.
- R11: A hardware update of status, cause or exception PC (trap entry or MRET) overrides a software write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_sw_i | input | 1 | Software interrupt request line |
| irq_tmr_i | input | 1 | Timer interrupt request line |
| irq_ext_i | input | 1 | External interrupt request line |
| pc_i | input | XLEN | PC of the instruction in the deciding stage |
| mret_i | input | 1 | MRET retire strobe |
| wr_status_i | input | 1 | Software write strobe, status |
| wr_ie_i | input | 1 | Software write strobe, interrupt enable |
| wr_ip_i | input | 1 | Software write strobe, interrupt pending |
| wr_tvec_i | input | 1 | Software write strobe, trap vector |
| wr_epc_i | input | 1 | Software write strobe, exception PC |
| wr_cause_i | input | 1 | Software write strobe, cause |
| wr_data_i | input | XLEN | Shared write data |
| redir_vld_o | output | 1 | One-cycle redirect pulse |
| redir_pc_o | output | XLEN | Redirect target |
| status_o | output | XLEN | Status register |
| ie_o | output | XLEN | Interrupt enable register |
| ip_o | output | XLEN | Interrupt pending register |
| tvec_o | output | XLEN | Trap vector register |
| epc_o | output | XLEN | Exception PC register |
| cause_o | output | XLEN | Cause register |

## Verification
The assertions assume that the request lines are 0 while reset is held. The pending bits must not start out of step with the lines, and the bench keeps all three lines low until reset is released. They also assume that at most one write strobe is raised per cycle, because the write data is shared. Every bench write goes through one task that raises a single strobe for one cycle. The MRET strobe is treated as a retire event, not a level. The bench pulses it for one cycle, including once in the very cycle where an interrupt would otherwise be taken.

// File: rtl/mtrap_pkg.sv
// Package: shared constants and types for the machine-mode interrupt trap
// controller. It fixes the interrupt bit positions, the status-bit layout
// and the priority order of the sources.
package mtrap_pkg;

    // Interrupt bit positions in the enable/pending registers (also the cause codes)
    localparam int IRQ_SW_POS  = 3;
    localparam int IRQ_TMR_POS = 7;
    localparam int IRQ_EXT_POS = 11;
    localparam int NUM_SRC     = 3;
    localparam int CODE_W      = 5;

    // Status register fields
    localparam int          ST_MIE_POS  = 3;
    localparam int          ST_MPIE_POS = 7;
    localparam int          ST_MPP_LO   = 11;
    localparam logic [1:0]  PRIV_MACH   = 2'b11;

    // Bit position of the source at a given priority rank (rank 0 = highest)
    function automatic int src_pos(input int rank);
        case (rank)
            0:       return IRQ_EXT_POS;
            1:       return IRQ_SW_POS;
            default: return IRQ_TMR_POS;
        endcase
    endfunction

    // Hardware event applied to the trap state in a given cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_MRET = 2'd2
    } trap_ev_e;

endpackage

// File: rtl/mtrap_pending.sv
// Module: interrupt pending register.
// The timer and external bits copy their request lines every cycle and ignore
// software writes. The software bit is set by its request line and is
// otherwise writable. All other bits read as zero.
// Assumes: the request lines are synchronous to clk.
module mtrap_pending
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM_SRC-1:0] line_i,   // indexed by priority rank
    input  logic            wr_i,
    input  logic            wbit_sw_i,
    output logic [XLEN-1:0] ip_o
);

    logic [NUM_SRC-1:0] bits_q;

    for (genvar r = 0; r < NUM_SRC; r++) begin : g_src
        localparam int POS = src_pos(r);
        if (POS == IRQ_SW_POS) begin : g_sw
            // Software-writable bit, forced high while its line is raised
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bits_q[r] <= 1'b0;
                else if (line_i[r])
                    bits_q[r] <= 1'b1;
                else if (wr_i)
                    bits_q[r] <= wbit_sw_i;
            end
        end else begin : g_hw
            // Read-only bit that follows its request line
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bits_q[r] <= 1'b0;
                else
                    bits_q[r] <= line_i[r];
            end
        end
    end

    // Place the per-source bits at their architectural positions
    always_comb begin
        ip_o = '0;
        for (int r = 0; r < NUM_SRC; r++)
            ip_o[src_pos(r)] = bits_q[r];
    end

endmodule

// File: rtl/mtrap_arbiter.sv
// Module: interrupt take decision and priority selection.
// Purely combinational. It works on registered enable/pending/status values,
// so the decision path is one AND-OR level plus a priority mux.
// Assumes: mret_i is a single-cycle retire strobe; MRET wins over any take.
module mtrap_arbiter
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   ie_i,
    input  logic [XLEN-1:0]   ip_i,
    input  logic              mie_i,
    input  logic              mret_i,
    output logic              take_o,
    output logic [CODE_W-1:0] code_o,
    output trap_ev_e          ev_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar r = 0; r < NUM_SRC; r++) begin : g_hit
        localparam int POS = src_pos(r);
        assign hit[r] = ie_i[POS] & ip_i[POS];
    end

    // Pick the code of the highest-ranked hit (rank 0 first)
    always_comb begin
        code_o = '0;
        for (int r = NUM_SRC - 1; r >= 0; r--)
            if (hit[r]) code_o = CODE_W'(src_pos(r));
    end

    // An interrupt is taken only with global enable set and no MRET this cycle
    assign take_o = mie_i & (|hit) & ~mret_i;

    // Encode the hardware event for the state registers
    always_comb begin
        if (mret_i)      ev_o = EV_MRET;
        else if (take_o) ev_o = EV_TRAP;
        else             ev_o = EV_NONE;
    end

endmodule

// File: rtl/mtrap_csr_file.sv
// Module: trap-state registers (status, enable, vector, exception PC, cause).
// It applies masked software writes and the hardware updates on trap entry
// and MRET. A hardware update wins over a same-cycle software write.
// Assumes: at most one write strobe per cycle; ev_i is EV_NONE/EV_TRAP/EV_MRET.
module mtrap_csr_file
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trap_ev_e          ev_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              wr_status_i,
    input  logic              wr_ie_i,
    input  logic              wr_tvec_i,
    input  logic              wr_epc_i,
    input  logic              wr_cause_i,
    input  logic [XLEN-1:0]   wr_data_i,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   ie_o,
    output logic [XLEN-1:0]   tvec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o
);

    localparam logic [XLEN-1:0] ONE      = XLEN'(1);
    localparam logic [XLEN-1:0] IE_MASK  = (ONE << IRQ_SW_POS) | (ONE << IRQ_TMR_POS)
                                         | (ONE << IRQ_EXT_POS);
    localparam logic [XLEN-1:0] ST_MASK  = (ONE << ST_MIE_POS) | (ONE << ST_MPIE_POS)
                                         | (ONE << ST_MPP_LO) | (ONE << (ST_MPP_LO + 1));
    localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] INT_FLAG = ONE << (XLEN - 1);

    logic [XLEN-1:0] status_q, status_d;
    logic [XLEN-1:0] ie_q, tvec_q, epc_q, epc_d, cause_q, cause_d;

    // Next status: hardware stacking first, then masked software write
    always_comb begin
        status_d = status_q;
        unique case (ev_i)
            EV_TRAP: begin
                status_d[ST_MPIE_POS]       = status_q[ST_MIE_POS];
                status_d[ST_MIE_POS]        = 1'b0;
                status_d[ST_MPP_LO +: 2]    = PRIV_MACH;
            end
            EV_MRET: begin
                status_d[ST_MIE_POS]        = status_q[ST_MPIE_POS];
                status_d[ST_MPIE_POS]       = 1'b1;
                status_d[ST_MPP_LO +: 2]    = PRIV_MACH;
            end
            default: begin
                if (wr_status_i) status_d = wr_data_i & ST_MASK;
            end
        endcase
    end

    // Next exception PC and cause: trap entry overrides software writes
    always_comb begin
        epc_d   = epc_q;
        cause_d = cause_q;
        if (ev_i == EV_TRAP) begin
            epc_d   = pc_i;
            cause_d = INT_FLAG | XLEN'(code_i);
        end else if (ev_i == EV_NONE) begin
            if (wr_epc_i)   epc_d   = wr_data_i;
            if (wr_cause_i) cause_d = wr_data_i;
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            ie_q     <= '0;
            tvec_q   <= '0;
            epc_q    <= '0;
            cause_q  <= '0;
        end else begin
            status_q <= status_d;
            epc_q    <= epc_d;
            cause_q  <= cause_d;
            if (wr_ie_i)   ie_q   <= wr_data_i & IE_MASK;
            if (wr_tvec_i) tvec_q <= wr_data_i & VEC_MASK;
        end
    end

    assign status_o = status_q;
    assign ie_o     = ie_q;
    assign tvec_o   = tvec_q;
    assign epc_o    = epc_q;
    assign cause_o  = cause_q;

endmodule

// File: rtl/mtrap_redirect.sv
// Module: registered redirect pulse and target.
// The target is the trap vector on interrupt entry and the saved exception PC
// on MRET. Both use the register values of the deciding cycle.
// Assumes: ev_i is never EV_TRAP and EV_MRET at once (guaranteed by the arbiter).
module mtrap_redirect
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trap_ev_e        ev_i,
    input  logic [XLEN-1:0] tvec_i,
    input  logic [XLEN-1:0] epc_i,
    output logic            vld_o,
    output logic [XLEN-1:0] pc_o
);

    // One-cycle redirect register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            pc_o  <= '0;
        end else begin
            vld_o <= (ev_i != EV_NONE);
            if (ev_i == EV_MRET)      pc_o <= epc_i;
            else if (ev_i == EV_TRAP) pc_o <= tvec_i;
        end
    end

endmodule

// File: rtl/mtrap_irq_ctrl.sv
// Module: top of the machine-mode interrupt trap controller.
// It joins the pending register, the take arbiter, the trap-state registers
// and the redirect register. The decision uses registered state only, so a
// redirect appears one cycle after the deciding cycle.
// Assumes: machine mode only, direct trap vector, no delegation.
module mtrap_irq_ctrl
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_sw_i,
    input  logic            irq_tmr_i,
    input  logic            irq_ext_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            mret_i,
    input  logic            wr_status_i,
    input  logic            wr_ie_i,
    input  logic            wr_ip_i,
    input  logic            wr_tvec_i,
    input  logic            wr_epc_i,
    input  logic            wr_cause_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic            redir_vld_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] ie_o,
    output logic [XLEN-1:0] ip_o,
    output logic [XLEN-1:0] tvec_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] cause_o
);

    logic [NUM_SRC-1:0] lines_w;
    logic               take_w;
    logic [CODE_W-1:0]  code_w;
    trap_ev_e           ev_w;

    // Request lines ordered by priority rank (external, software, timer)
    assign lines_w = {irq_tmr_i, irq_sw_i, irq_ext_i};

    mtrap_pending #(.XLEN(XLEN)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (lines_w),
        .wr_i      (wr_ip_i),
        .wbit_sw_i (wr_data_i[IRQ_SW_POS]),
        .ip_o      (ip_o)
    );

    mtrap_arbiter #(.XLEN(XLEN)) u_arb (
        .ie_i   (ie_o),
        .ip_i   (ip_o),
        .mie_i  (status_o[ST_MIE_POS]),
        .mret_i (mret_i),
        .take_o (take_w),
        .code_o (code_w),
        .ev_o   (ev_w)
    );

    mtrap_csr_file #(.XLEN(XLEN)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev_w),
        .code_i      (code_w),
        .pc_i        (pc_i),
        .wr_status_i (wr_status_i),
        .wr_ie_i     (wr_ie_i),
        .wr_tvec_i   (wr_tvec_i),
        .wr_epc_i    (wr_epc_i),
        .wr_cause_i  (wr_cause_i),
        .wr_data_i   (wr_data_i),
        .status_o    (status_o),
        .ie_o        (ie_o),
        .tvec_o      (tvec_o),
        .epc_o       (epc_o),
        .cause_o     (cause_o)
    );

    mtrap_redirect #(.XLEN(XLEN)) u_redir (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev_w),
        .tvec_i (tvec_o),
        .epc_i  (epc_o),
        .vld_o  (redir_vld_o),
        .pc_o   (redir_pc_o)
    );

endmodule

// File: rtl/mtrap_irq_checker.sv
// Module: property checker for the interrupt trap controller, bound to the top.
// Assumes: request lines are low while reset is held.
module mtrap_irq_checker
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_tmr_i,
    input logic              irq_ext_i,
    input logic              mret_i,
    input logic [XLEN-1:0]   pc_i,
    input logic              take,
    input logic              redir_vld_o,
    input logic [XLEN-1:0]   redir_pc_o,
    input logic [XLEN-1:0]   status_o,
    input logic [XLEN-1:0]   ie_o,
    input logic [XLEN-1:0]   ip_o,
    input logic [XLEN-1:0]   tvec_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [XLEN-1:0]   cause_o
);

    logic armed;

    // Marks that at least one clock edge has passed outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: hardware pending bits follow the lines one cycle late
    p_ip_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (ip_o[IRQ_TMR_POS] == $past(irq_tmr_i)) && (ip_o[IRQ_EXT_POS] == $past(irq_ext_i)));

    // R3: a take needs global enable and an enabled pending source
    p_take_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> status_o[ST_MIE_POS] && ((ie_o & ip_o) != '0));

    // R4: an enabled pending external source always wins
    p_ext_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ie_o[IRQ_EXT_POS] && ip_o[IRQ_EXT_POS]) |=> (cause_o[CODE_W-1:0] == CODE_W'(IRQ_EXT_POS)));

    // R5: status stacking on interrupt entry
    p_trap_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !status_o[ST_MIE_POS] && (status_o[ST_MPIE_POS] == $past(status_o[ST_MIE_POS]))
                 && (status_o[ST_MPP_LO +: 2] == PRIV_MACH));

    // R6: cause flag and captured PC on interrupt entry
    p_trap_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cause_o[XLEN-1] && (epc_o == $past(pc_i)));

    // R7: redirect to the trap vector after a take
    p_trap_redir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redir_vld_o && (redir_pc_o == $past(tvec_o)));

    // R8: status restore and redirect target on MRET
    p_mret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mret_i |=> status_o[ST_MPIE_POS] && (status_o[ST_MIE_POS] == $past(status_o[ST_MPIE_POS]))
                   && redir_vld_o && (redir_pc_o == $past(epc_o)));

    // R9: MRET blocks a take in the same cycle
    p_mret_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mret_i |-> !take);

    // R7, R8: a redirect only follows a take or an MRET
    p_redir_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && redir_vld_o) |-> ($past(take) || $past(mret_i)));

endmodule

bind mtrap_irq_ctrl mtrap_irq_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_tmr_i   (irq_tmr_i),
    .irq_ext_i   (irq_ext_i),
    .mret_i      (mret_i),
    .pc_i        (pc_i),
    .take        (take_w),
    .redir_vld_o (redir_vld_o),
    .redir_pc_o  (redir_pc_o),
    .status_o    (status_o),
    .ie_o        (ie_o),
    .ip_o        (ip_o),
    .tvec_o      (tvec_o),
    .epc_o       (epc_o),
    .cause_o     (cause_o)
);

// File: tb/sim_mtrap_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the interrupt trap controller, one task each.
module sim_mtrap_irq_ctrl;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_sw = 1'b0, irq_tmr = 1'b0, irq_ext = 1'b0;
    logic [XLEN-1:0] pc = '0;
    logic            mret = 1'b0;
    logic            w_st = 1'b0, w_ie = 1'b0, w_ip = 1'b0, w_tv = 1'b0, w_epc = 1'b0, w_ca = 1'b0;
    logic [XLEN-1:0] wdata = '0;
    logic            redir_vld;
    logic [XLEN-1:0] redir_pc, status, ie, ip, tvec, epc, cause;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mtrap_irq_ctrl #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .irq_sw_i(irq_sw), .irq_tmr_i(irq_tmr), .irq_ext_i(irq_ext),
        .pc_i(pc), .mret_i(mret),
        .wr_status_i(w_st), .wr_ie_i(w_ie), .wr_ip_i(w_ip),
        .wr_tvec_i(w_tv), .wr_epc_i(w_epc), .wr_cause_i(w_ca),
        .wr_data_i(wdata),
        .redir_vld_o(redir_vld), .redir_pc_o(redir_pc),
        .status_o(status), .ie_o(ie), .ip_o(ip),
        .tvec_o(tvec), .epc_o(epc), .cause_o(cause)
    );

    task automatic check(input string req, input string what, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: inputs were set at a falling edge, outputs read at the next one
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Single-strobe software write: 0 status, 1 enable, 2 pending, 3 vector, 4 epc, 5 cause
    task automatic wr(input int sel, input logic [XLEN-1:0] d);
        wdata = d;
        w_st = (sel == 0); w_ie = (sel == 1); w_ip = (sel == 2);
        w_tv = (sel == 3); w_epc = (sel == 4); w_ca = (sel == 5);
        tick();
        {w_st, w_ie, w_ip, w_tv, w_epc, w_ca} = '0;
    endtask

    task automatic t_reset();
        check("R1", "redir_vld", XLEN'(redir_vld), '0);
        check("R1", "status", status, '0);
        check("R1", "ie", ie, '0);
        check("R1", "ip", ip, '0);
        check("R1", "tvec", tvec, '0);
        check("R1", "epc", epc, '0);
        check("R1", "cause", cause, '0);
    endtask

    task automatic t_masks();
        wr(1, 32'hFFFF_FFFF);
        check("R10", "ie mask", ie, 32'h0000_0888);
        wr(3, 32'h0000_1237);
        check("R10", "tvec mask", tvec, 32'h0000_1234);
        wr(0, 32'hFFFF_FFFF);
        check("R10", "status mask", status, 32'h0000_1888);
        tick();
        check("R3", "no trap without pending", XLEN'(redir_vld), '0);
        wr(0, '0);
        wr(1, '0);
    endtask

    task automatic t_pending();
        wr(2, 32'hFFFF_FFFF);
        check("R2", "ip write keeps only sw bit", ip, 32'h0000_0008);
        wr(2, '0);
        check("R2", "ip sw bit cleared", ip, '0);
        irq_tmr = 1'b1;
        tick();
        check("R2", "timer line copied", ip, 32'h0000_0080);
        wr(2, '0);
        check("R2", "timer bit ignores write", ip, 32'h0000_0080);
        irq_ext = 1'b1;
        tick();
        check("R2", "external line copied", ip, 32'h0000_0880);
        irq_tmr = 1'b0; irq_ext = 1'b0;
        tick();
        check("R2", "lines dropped", ip, '0);
    endtask

    task automatic t_gate();
        wr(3, 32'h0000_0200);
        irq_tmr = 1'b1;
        wr(1, 32'h0000_0008);
        wr(0, 32'h0000_0008);
        tick(); tick();
        check("R3", "no trap, source disabled", XLEN'(redir_vld), '0);
        check("R3", "status untouched", status, 32'h0000_0008);
        wr(0, '0);
        wr(1, 32'h0000_0080);
        tick(); tick();
        check("R3", "no trap, global enable off", XLEN'(redir_vld), '0);
    endtask

    task automatic t_trap();
        pc = 32'h4000_0010;
        wr(0, 32'h0000_0008);
        check("R3", "no trap in enabling cycle", XLEN'(redir_vld), '0);
        tick();
        check("R7", "redirect valid", XLEN'(redir_vld), 1);
        check("R7", "redirect target", redir_pc, 32'h0000_0200);
        check("R6", "cause timer", cause, 32'h8000_0007);
        check("R6", "epc", epc, 32'h4000_0010);
        check("R5", "status stacked", status, 32'h0000_1880);
        tick();
        check("R7", "redirect one cycle", XLEN'(redir_vld), '0);
        irq_tmr = 1'b0;
    endtask

    task automatic t_priority_mret();
        irq_sw = 1'b1; irq_tmr = 1'b1; irq_ext = 1'b1;
        wr(1, 32'h0000_0888);
        wr(0, 32'h0000_0008);
        tick();
        check("R4", "external first", cause, 32'h8000_000B);
        check("R5", "status after ext trap", status, 32'h0000_1880);
        irq_ext = 1'b0;
        pc = 32'h4000_0020;
        mret = 1'b1;
        tick();
        mret = 1'b0;
        check("R8", "status restored", status, 32'h0000_1888);
        check("R8", "mret redirect valid", XLEN'(redir_vld), 1);
        check("R8", "mret target", redir_pc, 32'h4000_0010);
        tick();
        check("R4", "software before timer", cause, 32'h8000_0003);
        check("R6", "epc second trap", epc, 32'h4000_0020);
        check("R7", "redirect after re-enable", redir_pc, 32'h0000_0200);
    endtask

    task automatic t_race();
        wr(0, 32'h0000_0088);
        mret = 1'b1;
        tick();
        mret = 1'b0;
        check("R9", "mret performed", redir_pc, 32'h4000_0020);
        check("R9", "status after mret", status, 32'h0000_1888);
        check("R9", "no cause update", cause, 32'h8000_0003);
        pc = 32'h4000_0030;
        wdata = 32'hDEAD_0000;
        w_epc = 1'b1;
        tick();
        w_epc = 1'b0;
        check("R9", "deferred trap taken", redir_pc, 32'h0000_0200);
        check("R11", "hardware epc wins", epc, 32'h4000_0030);
        check("R9", "status after deferred trap", status, 32'h0000_1880);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_pending();
        t_gate();
        t_trap();
        t_priority_mret();
        t_race();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule